// File: doc/BRIEF.md
# Scanline Fetch Sequencer and Frame Timer

This block keeps the raster timing of a tile-based video processor in master clock cycles. It tracks a cycle position inside each line and a line position inside each frame, and it names the memory fetch that belongs to the current moment. The fetch is given as a one-cycle strobe, a kind code and a slot number. Address generation, pixel output and the memory itself sit outside the block; a downstream address unit turns each strobe, kind and slot into an access.

A line has 170 fetch slots of 8 cycles each, then 4 idle cycles. Slots are grouped as follows: background tiles for the current line, then sprite pattern fetches mixed with throw-away name fetches, then a prefetch of the first two tiles of the next line, then two lone name fetches. A frame starts with a vertical interval with no fetches. After that come one pre-render line, the visible lines and one idle line. A parity bit flips on every frame. On frames where that bit is set and rendering is on, the pre-render line loses its 4 idle cycles.

The fetch interface has a strobe but no ready input, so there is no back-pressure. The consumer must accept every strobe in the cycle it appears, because the raster cannot stall. All other pins are plain control and status.

Top module: `line_fetch_timer`

## Requirements
- R1: `cycle_idx` counts 0 to 1363 (line length 1364 cycles) and then returns to 0. At that return `line_idx` increases by one. The one exception is the short line of R10.
- R2: `fetch_valid` is high for exactly one cycle when `cycle_idx` is a multiple of 8 below 1360. It only rises on a fetch line with rendering enabled. At that cycle `fetch_slot` equals `cycle_idx/8` (0 to 169). No strobe is given in cycles 1360 to 1363.
- R3: Kind codes are 0 none, 1 name, 2 attribute, 3 pattern low, 4 pattern high, 5 throw-away name, 6 sprite pattern low and 7 sprite pattern high. In slots 0 to 127, slot mod 4 selects name, attribute, pattern low or pattern high, in that order. When `fetch_valid` is low, kind and slot are both 0.
- R4: In slots 128 to 159, slot mod 4 equal to 0 or 1 gives kind 5, 2 gives kind 6 and 3 gives kind 7.
- R5: Slots 160 to 167 follow the background order of R3. Slots 168 and 169 are each kind 1.
- R6: A frame has VINT_LINES + VIS_LINES + 2 lines, which is 262 by default. Line VINT_LINES is the pre-render line and the last line is idle. Fetches happen only from the pre-render line through the last visible line. The default frame lasts 357368 cycles when no short line occurs.
- R7: `vblank` is high exactly on lines 0 to VINT_LINES-1. It rises when the idle line ends.
- R8: While `render_en` is low, `fetch_valid` stays low.
- R9: `odd_frame` flips each time the last line wraps to line 0, whatever the state of `render_en`.
- R10: The pre-render line ends after cycle 1359 when `odd_frame` is 1 and `render_en` is high in that cycle. The next line then starts at `cycle_idx` 0.
- R11: After reset, `cycle_idx`, `line_idx` and `odd_frame` are 0 and `vblank` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| render_en | input | 1 | Rendering enable |
| fetch_valid | output | 1 | One-cycle fetch strobe (no ready) |
| fetch_kind | output | 3 | Fetch kind code |
| fetch_slot | output | 8 | Fetch slot number 0..169 |
| cycle_idx | output | CYC_W (11) | Cycle within the line |
| line_idx | output | LINE_W (9) | Line within the frame |
| vblank | output | 1 | Vertical interval flag |
| odd_frame | output | 1 | Frame parity |

## Verification
The assertions assume only that `render_en` is a clean level that may change in any cycle. Because the block has no back-pressure, no handshake assumption is needed. `render_en` is also the only input that can change the line length, so the stimulus holds it high for whole frames, low for a whole frame, and then toggles it at random intervals. The random toggling catches enable changes that land on the last cycle of the short pre-render line. The bench is built with a shortened vertical interval and fewer visible lines so that several frames fit in the run. The line and slot structure stays at full size.

// File: rtl/lft_pkg.sv
package lft_pkg;
  typedef enum logic [2:0] {
    FK_NONE       = 3'd0,
    FK_NAME       = 3'd1,
    FK_ATTR       = 3'd2,
    FK_PAT_LO     = 3'd3,
    FK_PAT_HI     = 3'd4,
    FK_DUMMY_NAME = 3'd5,
    FK_SPR_LO     = 3'd6,
    FK_SPR_HI     = 3'd7
  } fetch_kind_e;
endpackage

// File: rtl/lft_beam_counter.sv
module lft_beam_counter #(
  parameter int CYC_W      = 11,
  parameter int LINE_W     = 9,
  parameter int LAST_CYC   = 1363,
  parameter int SHORT_LAST = 1359,
  parameter int LAST_LINE  = 261,
  parameter int PRE_LINE   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              render_en,
  output logic [CYC_W-1:0]  cycle,
  output logic [LINE_W-1:0] line,
  output logic              odd
);
  localparam logic [CYC_W-1:0]  LAST_C  = CYC_W'(LAST_CYC);
  localparam logic [CYC_W-1:0]  SHORT_C = CYC_W'(SHORT_LAST);
  localparam logic [LINE_W-1:0] LAST_L  = LINE_W'(LAST_LINE);
  localparam logic [LINE_W-1:0] PRE_L   = LINE_W'(PRE_LINE);

  logic short_end;
  logic line_end;

  // the pre-render line drops its idle tail on odd rendered frames
  assign short_end = (line == PRE_L) && odd && render_en && (cycle == SHORT_C);
  assign line_end  = (cycle == LAST_C) || short_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cycle <= '0;
      line  <= '0;
      odd   <= 1'b0;
    end else if (line_end) begin
      cycle <= '0;
      if (line == LAST_L) begin
        line <= '0;
        odd  <= ~odd;
      end else begin
        line <= line + 1'b1;
      end
    end else begin
      cycle <= cycle + 1'b1;
    end
  end
endmodule

// File: rtl/lft_slot_decode.sv
module lft_slot_decode
  import lft_pkg::*;
#(
  parameter int SLOT_W   = 8,
  parameter int BG_END   = 128,
  parameter int SPR_END  = 160,
  parameter int PREF_END = 168
) (
  input  logic [SLOT_W-1:0] slot,
  output fetch_kind_e       kind
);
  localparam logic [SLOT_W-1:0] BG_E  = SLOT_W'(BG_END);
  localparam logic [SLOT_W-1:0] SPR_E = SLOT_W'(SPR_END);
  localparam logic [SLOT_W-1:0] PRE_E = SLOT_W'(PREF_END);

  fetch_kind_e tile_kind;
  fetch_kind_e sprite_kind;

  always_comb begin
    case (slot[1:0])
      2'd0:    tile_kind = FK_NAME;
      2'd1:    tile_kind = FK_ATTR;
      2'd2:    tile_kind = FK_PAT_LO;
      default: tile_kind = FK_PAT_HI;
    endcase
  end

  always_comb begin
    if (!slot[1])     sprite_kind = FK_DUMMY_NAME;
    else if (slot[0]) sprite_kind = FK_SPR_HI;
    else              sprite_kind = FK_SPR_LO;
  end

  always_comb begin
    if (slot < BG_E)       kind = tile_kind;
    else if (slot < SPR_E) kind = sprite_kind;
    else if (slot < PRE_E) kind = tile_kind;
    else                   kind = FK_NAME;
  end
endmodule

// File: rtl/line_fetch_timer.sv
module line_fetch_timer
  import lft_pkg::*;
#(
  parameter int SLOT_CYC     = 8,
  parameter int TILES        = 32,
  parameter int SPRITES      = 8,
  parameter int PREF_TILES   = 2,
  parameter int TAIL_NAMES   = 2,
  parameter int IDLE_CYC     = 4,
  parameter int VINT_LINES   = 20,
  parameter int VIS_LINES    = 240,
  parameter int CYC_W        = 11,
  parameter int LINE_W       = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              render_en,
  output logic              fetch_valid,
  output logic [2:0]        fetch_kind,
  output logic [7:0]        fetch_slot,
  output logic [CYC_W-1:0]  cycle_idx,
  output logic [LINE_W-1:0] line_idx,
  output logic              vblank,
  output logic              odd_frame
);
  localparam int GROUP      = 4;
  localparam int BG_END     = TILES * GROUP;
  localparam int SPR_END    = BG_END + SPRITES * GROUP;
  localparam int PREF_END   = SPR_END + PREF_TILES * GROUP;
  localparam int N_SLOTS    = PREF_END + TAIL_NAMES;
  localparam int FETCH_CYC  = N_SLOTS * SLOT_CYC;
  localparam int LINE_CYC   = FETCH_CYC + IDLE_CYC;
  localparam int SLOT_SHIFT = $clog2(SLOT_CYC);
  localparam int PRE_LINE   = VINT_LINES;
  localparam int LAST_VIS   = PRE_LINE + VIS_LINES;
  localparam int LAST_LINE  = LAST_VIS + 1;

  localparam logic [CYC_W-1:0]  FETCH_E = CYC_W'(FETCH_CYC);
  localparam logic [LINE_W-1:0] PRE_L   = LINE_W'(PRE_LINE);
  localparam logic [LINE_W-1:0] VIS_L   = LINE_W'(LAST_VIS);

  logic        fetch_line;
  logic        on_slot;
  logic [7:0]  slot_raw;
  fetch_kind_e kind_raw;

  lft_beam_counter #(
    .CYC_W(CYC_W), .LINE_W(LINE_W),
    .LAST_CYC(LINE_CYC - 1), .SHORT_LAST(FETCH_CYC - 1),
    .LAST_LINE(LAST_LINE), .PRE_LINE(PRE_LINE)
  ) u_beam (
    .clk(clk), .rst_n(rst_n), .render_en(render_en),
    .cycle(cycle_idx), .line(line_idx), .odd(odd_frame)
  );

  assign slot_raw = 8'(cycle_idx >> SLOT_SHIFT);

  lft_slot_decode #(
    .SLOT_W(8), .BG_END(BG_END), .SPR_END(SPR_END), .PREF_END(PREF_END)
  ) u_dec (
    .slot(slot_raw), .kind(kind_raw)
  );

  assign fetch_line  = (line_idx >= PRE_L) && (line_idx <= VIS_L);
  assign on_slot     = (cycle_idx[SLOT_SHIFT-1:0] == '0) && (cycle_idx < FETCH_E);
  assign fetch_valid = render_en && fetch_line && on_slot;
  assign fetch_kind  = fetch_valid ? kind_raw : FK_NONE;
  assign fetch_slot  = fetch_valid ? slot_raw : 8'd0;
  assign vblank      = line_idx < PRE_L;
endmodule

// File: rtl/lft_checks.sv
module lft_checks #(
  parameter int CYC_W      = 11,
  parameter int LINE_W     = 9,
  parameter int SLOT_SHIFT = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              render_en,
  input logic              fetch_valid,
  input logic [2:0]        fetch_kind,
  input logic [CYC_W-1:0]  cycle_idx,
  input logic [LINE_W-1:0] line_idx,
  input logic              vblank,
  input logic              odd_frame
);
  assert_fetch_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> render_en);

  assert_slot_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> (cycle_idx[SLOT_SHIFT-1:0] == '0));

  assert_kind_with_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> (fetch_kind != 3'd0));

  assert_kind_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |-> (fetch_kind == 3'd0));

  assert_quiet_vblank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vblank |-> !fetch_valid);

  assert_cycle_advance_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_idx != '0) |-> (cycle_idx == $past(cycle_idx) + 1'b1));

  assert_parity_at_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (odd_frame != $past(odd_frame)) |-> (line_idx == '0 && cycle_idx == '0));
endmodule

bind line_fetch_timer lft_checks #(
  .CYC_W(CYC_W), .LINE_W(LINE_W), .SLOT_SHIFT(SLOT_SHIFT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .render_en(render_en),
  .fetch_valid(fetch_valid), .fetch_kind(fetch_kind),
  .cycle_idx(cycle_idx), .line_idx(line_idx),
  .vblank(vblank), .odd_frame(odd_frame)
);

// File: tb/sim_line_fetch_timer.sv
`timescale 1ns/1ps
module sim_line_fetch_timer;
  localparam int VINT = 3;
  localparam int VIS  = 8;
  localparam int PRE  = VINT;
  localparam int LAST = VINT + VIS + 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       render_en = 1'b0;
  logic       fetch_valid;
  logic [2:0] fetch_kind;
  logic [7:0] fetch_slot;
  logic [10:0] cycle_idx;
  logic [8:0] line_idx;
  logic       vblank;
  logic       odd_frame;

  int checks = 0;
  int errors = 0;
  int shorts = 0;
  bit done = 1'b0;

  int  mc, ml;
  bit  modd, just_short;
  int  mode;
  int  hold;

  always #10 clk = ~clk;

  line_fetch_timer #(.VINT_LINES(VINT), .VIS_LINES(VIS), .CYC_W(11), .LINE_W(9)) u0 (
    .clk(clk), .rst_n(rst_n), .render_en(render_en),
    .fetch_valid(fetch_valid), .fetch_kind(fetch_kind), .fetch_slot(fetch_slot),
    .cycle_idx(cycle_idx), .line_idx(line_idx), .vblank(vblank), .odd_frame(odd_frame)
  );

  function automatic int exp_kind(input int s);
    int r = s % 4;
    if (s >= 168) return 1;
    if (s >= 128 && s < 160) return (r < 2) ? 5 : (r == 2 ? 6 : 7);
    return r + 1;
  endfunction

  function automatic string kind_tag(input int s);
    if (s < 128) return "R3";
    if (s < 160) return "R4";
    return "R5";
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s line=%0d cyc=%0d actual=%0d expected=%0d", tag, ml, mc, act, exp);
    end
  endtask

  task automatic compare();
    bit fl, ev;
    int s;
    fl = (ml >= PRE) && (ml <= PRE + VIS);
    ev = render_en && fl && (mc % 8 == 0) && (mc < 1360);
    s  = mc / 8;
    chk(just_short ? "R10" : "R1", int'(cycle_idx), mc);
    chk(just_short ? "R10" : "R6", int'(line_idx), ml);
    chk("R7", int'(vblank), int'(ml < PRE));
    chk("R9", int'(odd_frame), int'(modd));
    if (!render_en) chk("R8", int'(fetch_valid), 0);
    else            chk("R2", int'(fetch_valid), int'(ev));
    chk(ev ? kind_tag(s) : "R3", int'(fetch_kind), ev ? exp_kind(s) : 0);
    chk("R2", int'(fetch_slot), ev ? s : 0);
  endtask

  task automatic advance(input bit r);
    just_short = 1'b0;
    if (mc == 1363 || (ml == PRE && modd && r && mc == 1359)) begin
      if (mc == 1359) begin just_short = 1'b1; shorts++; end
      mc = 0;
      if (ml == LAST) begin ml = 0; modd = ~modd; end
      else ml++;
    end else begin
      mc++;
    end
  endtask

  task automatic step();
    bit r;
    @(negedge clk);
    compare();
    case (mode)
      0: r = 1'b1;
      1: r = 1'b0;
      default: begin
        if (hold == 0) begin
          r = ~render_en;
          hold = int'($urandom_range(1, 3000));
        end else begin
          r = render_en;
          hold--;
        end
      end
    endcase
    render_en = r;
    advance(r);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    mc = 0; ml = 0; modd = 1'b0; just_short = 1'b0; mode = 0; hold = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    chk("R11", int'(cycle_idx), 0);
    chk("R11", int'(line_idx), 0);
    chk("R11", int'(odd_frame), 0);
    chk("R11", int'(vblank), 1);
    render_en = 1'b1;
    rst_n = 1'b1;
    // the first posedge after release advances from the reset state
    advance(1'b1);
    // directed: rendering on for two frames and a half (both parities)
    mode = 0;
    for (int i = 0; i < 2 * 17732 + 9000; i++) step();
    // directed: rendering off for a full frame
    mode = 1;
    for (int i = 0; i < 17732; i++) step();
    // random enable toggling
    mode = 2;
    for (int i = 0; i < 3 * 17732; i++) step();
    checks++;
    if (shorts < 1) begin
      errors++;
      $display("FAIL R10 short lines actual=%0d expected>=1", shorts);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(190000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule